// File: doc/BRIEF.md
# Page Write Collector with In-Page Rollover

This block gathers the data bytes of one page-programming transaction for a 64K x 8 non-volatile array organised in 128-byte pages. A transaction opens with a start pulse carrying a 16-bit byte address. The upper nine bits select the page and stay fixed. The low seven bits set the first slot of the page buffer. Each accepted byte goes into the current slot and sets that slot's valid flag. The slot pointer then advances by one and wraps from 127 back to 0, so a later byte overwrites an earlier one at the same slot.

Nothing reaches the memory side while bytes are arriving. When the transaction closes (the chip-select release from the serial front end), the block programs the array in 32-bit words, because storage is rewritten in 4-byte groups. Each word that holds at least one loaded byte is read, the loaded bytes replace the matching lanes, and the merged word is written back. Words without loaded bytes are skipped. A busy flag covers the whole commit. While busy is high, every transaction input is ignored.

Top module: `page_wbuf`

## Requirements
- R1: After reset, `busy` and `mem_req` are low.
- R2: Byte n (counting from 0) of a transaction lands at page offset (start_addr[6:0] + n) mod 128.
- R3: The pointer wraps from offset 127 to offset 0 of the same page. A byte loaded later into a slot replaces the earlier one.
- R4: Every memory access uses word address `mem_addr = {start_addr[15:7], offset[6:2]}` (14 bits). Page offset o sits in lane o[1:0] of that word, at bits 8*o[1:0]+7 down to 8*o[1:0].
- R5: No memory access occurs before the close pulse. `busy` rises in the cycle after an accepted close, and only then.
- R6: Each committed word is first read (`mem_we`=0) and then written (`mem_we`=1) at the same address. Lanes with no loaded byte keep the value that was read.
- R7: Only words holding at least one loaded byte are accessed, each exactly once, in ascending word order.
- R8: `mem_req` stays high, with `mem_addr` and `mem_we` stable, until `mem_ack`. `busy` stays high until the last write is acknowledged and falls in the next cycle.
- R9: A close with no loaded bytes causes no memory access, and `busy` stays low.
- R10: A start pulse clears all valid flags, including those from an earlier start that was never closed.
- R11: Start, byte and close inputs are ignored while `busy` is high. Bytes and close pulses outside an open transaction are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Opens a transaction and clears the valid flags |
| start_addr | input | 16 | Byte address sampled with txn_start |
| txn_close | input | 1 | Closes the transaction and starts the commit |
| byte_valid | input | 1 | Byte strobe |
| byte_data | input | 8 | Data byte |
| busy | output | 1 | Commit in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 14 | Word address: page and word index |
| mem_wdata | output | 32 | Merged write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack on a read |
| mem_ack | input | 1 | Access complete |

## Verification
A slot pointer that does not wrap, or that drifts from the start offset, shows up in the first word written back after close, as a byte sitting in the wrong lane or word. A stale or missing valid flag shows up at commit, either as an extra or missing memory access or as a lane that should have kept its old value but was overwritten. Handshake faults appear within one access: a request that drops before its acknowledge, a write whose address differs from the read before it, or busy ending before the last acknowledge. Inputs that should be ignored while busy betray themselves by changing later commit contents or by starting an unexpected second commit.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    localparam int LANES  = 4;
    localparam int WORD_W = 8 * LANES;

    typedef enum logic [1:0] {
        CM_IDLE  = 2'd0,
        CM_READ  = 2'd1,
        CM_WRITE = 2'd2
    } commit_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [LANES-1:0]  lane_en;
    } lane_word_t;

    // Replace enabled lanes of a stored word with buffered bytes.
    function automatic logic [WORD_W-1:0] merge_word(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [LANES-1:0]  en
    );
        logic [WORD_W-1:0] res;
        for (int l = 0; l < LANES; l++) begin
            res[8*l +: 8] = en[l] ? new_w[8*l +: 8] : old_w[8*l +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/wbuf_ptr.sv
module wbuf_ptr #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 7,
    localparam int PAGE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              adv,
    output logic [PAGE_W-1:0] page,
    output logic [OFF_W-1:0]  off
);

    always_ff @(posedge clk) begin
        if (rst) begin
            page <= '0;
            off  <= '0;
        end else if (load) begin
            page <= load_addr[ADDR_W-1:OFF_W];
            off  <= load_addr[OFF_W-1:0];
        end else if (adv) begin
            off <= off + 1'b1;      // natural wrap inside the page
        end
    end

endmodule

// File: rtl/wbuf_store.sv
module wbuf_store
    import wbuf_pkg::*;
#(
    parameter int SLOTS = 128,
    localparam int OFF_W  = $clog2(SLOTS),
    localparam int WORDS  = SLOTS / LANES,
    localparam int WIDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [7:0]        wr_data,
    input  logic [WIDX_W-1:0] rd_idx,
    output lane_word_t        rd_word,
    output logic [WORDS-1:0]  word_any
);

    logic [7:0]       slot [SLOTS];
    logic [SLOTS-1:0] valid;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            valid <= '0;
        end else if (wr_en) begin
            valid[wr_off] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot[wr_off] <= wr_data;
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign word_any[w] = |valid[w*LANES +: LANES];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign rd_word.data[8*l +: 8] = slot[{rd_idx, 2'(l)}];
        assign rd_word.lane_en[l]     = valid[{rd_idx, 2'(l)}];
    end

endmodule

// File: rtl/wbuf_commit.sv
module wbuf_commit
    import wbuf_pkg::*;
#(
    parameter int WORDS = 32,
    localparam int WIDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [WORDS-1:0]  word_any,
    output logic [WIDX_W-1:0] idx,
    input  lane_word_t        cur_word,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    commit_state_t     st;
    logic [WORDS-1:0]  done;
    logic [WORDS-1:0]  pend_nx;
    logic [WIDX_W-1:0] first_any;
    logic [WIDX_W-1:0] first_nx;
    logic [WORD_W-1:0] merged;

    function automatic logic [WIDX_W-1:0] lowest_set(input logic [WORDS-1:0] v);
        logic [WIDX_W-1:0] r;
        r = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (v[i]) r = WIDX_W'(i);
        end
        return r;
    endfunction

    always_comb begin
        pend_nx   = word_any & ~done & ~(WORDS'(1) << idx);
        first_any = lowest_set(word_any);
        first_nx  = lowest_set(pend_nx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= CM_IDLE;
            idx    <= '0;
            done   <= '0;
            merged <= '0;
        end else begin
            unique case (st)
                CM_IDLE: begin
                    if (go) begin
                        st   <= CM_READ;
                        idx  <= first_any;
                        done <= '0;
                    end
                end
                CM_READ: begin
                    if (mem_ack) begin
                        merged <= merge_word(mem_rdata, cur_word.data, cur_word.lane_en);
                        st     <= CM_WRITE;
                    end
                end
                CM_WRITE: begin
                    if (mem_ack) begin
                        done[idx] <= 1'b1;
                        if (|pend_nx) begin
                            idx <= first_nx;
                            st  <= CM_READ;
                        end else begin
                            st <= CM_IDLE;
                        end
                    end
                end
                default: st <= CM_IDLE;
            endcase
        end
    end

    assign busy      = (st != CM_IDLE);
    assign mem_req   = busy;
    assign mem_we    = (st == CM_WRITE);
    assign mem_wdata = merged;

endmodule

// File: rtl/page_wbuf.sv
module page_wbuf
    import wbuf_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 128,
    localparam int OFF_W   = $clog2(PAGE_BYTES),
    localparam int PAGE_W  = ADDR_W - OFF_W,
    localparam int WORDS   = PAGE_BYTES / LANES,
    localparam int WIDX_W  = $clog2(WORDS),
    localparam int MADDR_W = PAGE_W + WIDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               txn_start,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic               txn_close,
    input  logic               byte_valid,
    input  logic [7:0]         byte_data,
    output logic               busy,
    output logic               mem_req,
    output logic               mem_we,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               mem_ack
);

    logic              open_q;
    logic              do_start;
    logic              do_byte;
    logic              do_close;
    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  off;
    logic [WIDX_W-1:0] idx;
    logic [WORDS-1:0]  word_any;
    lane_word_t        cur_word;

    assign do_start = txn_start && !busy;
    assign do_close = open_q && txn_close && !txn_start && !busy;
    assign do_byte  = open_q && byte_valid && !txn_start && !txn_close && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else if (do_start) begin
            open_q <= 1'b1;
        end else if (do_close) begin
            open_q <= 1'b0;
        end
    end

    wbuf_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load      (do_start),
        .load_addr (start_addr),
        .adv       (do_byte),
        .page      (page),
        .off       (off)
    );

    wbuf_store #(.SLOTS(PAGE_BYTES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .clr      (do_start),
        .wr_en    (do_byte),
        .wr_off   (off),
        .wr_data  (byte_data),
        .rd_idx   (idx),
        .rd_word  (cur_word),
        .word_any (word_any)
    );

    wbuf_commit #(.WORDS(WORDS)) u_commit (
        .clk       (clk),
        .rst       (rst),
        .go        (do_close && (|word_any)),
        .word_any  (word_any),
        .idx       (idx),
        .cur_word  (cur_word),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack)
    );

    assign mem_addr = {page, idx};

endmodule

// File: rtl/page_wbuf_checker.sv
module page_wbuf_checker #(
    parameter int MADDR_W = 14,
    parameter int PAGE_W  = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               txn_close,
    input logic               busy,
    input logic               mem_req,
    input logic               mem_we,
    input logic [MADDR_W-1:0] mem_addr,
    input logic               mem_ack
);

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    p_busy_after_close_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(txn_close));

    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_busy_end_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(mem_req && mem_we && mem_ack));

    p_rd_then_wr_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && $stable(mem_addr)));

    p_page_fixed_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |->
            (mem_addr[MADDR_W-1 -: PAGE_W] == $past(mem_addr[MADDR_W-1 -: PAGE_W])));

endmodule

bind page_wbuf page_wbuf_checker #(.MADDR_W(MADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .txn_close (txn_close),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack)
);

// File: tb/test_page_wbuf.sv
module test_page_wbuf;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        txn_start = 1'b0;
    logic [15:0] start_addr = '0;
    logic        txn_close = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        busy;
    logic        mem_req;
    logic        mem_we;
    logic [13:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    // bench model
    logic [7:0]  eb [128];
    bit          em [128];
    int          eptr;
    logic [8:0]  epage;
    logic [31:0] bmem [32];
    logic [31:0] orig [32];
    bit          in_commit = 0;
    int          wr_cnt, acc_cnt, last_w, rd_idx;
    bit          rd_pend;

    always #5 clk = ~clk;

    page_wbuf i_page_wbuf (
        .clk(clk), .rst(rst), .txn_start(txn_start), .start_addr(start_addr),
        .txn_close(txn_close), .byte_valid(byte_valid), .byte_data(byte_data),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // memory responder with random latency
    initial begin
        int dly;
        int w;
        dly = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (dly > 0) begin
                    dly--;
                end else begin
                    w = int'(mem_addr[4:0]);
                    acc_cnt++;
                    check(in_commit, "R5", "access outside commit", 32'(mem_addr), 32'h0);
                    check(mem_addr[13:5] == epage, "R4", "page field", 32'(mem_addr[13:5]), 32'(epage));
                    if (!mem_we) begin
                        mem_rdata = bmem[w];
                        rd_idx    = w;
                        rd_pend   = 1;
                    end else begin
                        check(rd_pend && rd_idx == w, "R6", "write without read", 32'(w), 32'(rd_idx));
                        check(w > last_w, "R7", "word order", 32'(w), 32'(last_w + 1));
                        bmem[w] = mem_wdata;
                        last_w  = w;
                        rd_pend = 0;
                        wr_cnt++;
                    end
                    mem_ack = 1'b1;
                    dly = int'($urandom % 3);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    task automatic prep_page(input logic [8:0] pg);
        epage = pg;
        for (int i = 0; i < 32; i++) begin
            bmem[i] = $urandom;
            orig[i] = bmem[i];
        end
        wr_cnt = 0; acc_cnt = 0; last_w = -1; rd_pend = 0;
    endtask

    task automatic do_start(input logic [15:0] a);
        txn_start = 1'b1; start_addr = a;
        @(negedge clk);
        txn_start = 1'b0;
        eptr = int'(a[6:0]);
        for (int i = 0; i < 128; i++) em[i] = 0;
    endtask

    task automatic do_byte(input logic [7:0] d, input bit model);
        byte_valid = 1'b1; byte_data = d;
        @(negedge clk);
        byte_valid = 1'b0;
        if (model) begin
            eb[eptr] = d; em[eptr] = 1;
            eptr = (eptr + 1) % 128;
        end
    endtask

    function automatic int touched_words();
        int n = 0;
        for (int w = 0; w < 32; w++)
            if (em[4*w] || em[4*w+1] || em[4*w+2] || em[4*w+3]) n++;
        return n;
    endfunction

    function automatic logic [31:0] exp_word(input int w);
        logic [31:0] r = orig[w];
        for (int l = 0; l < 4; l++)
            if (em[4*w+l]) r[8*l +: 8] = eb[4*w+l];
        return r;
    endfunction

    // close, check busy one cycle later, wait for the commit, check memory
    task automatic close_and_check(input string tag, input bit extra_while_busy);
        int tw;
        int lim;
        bit ok;
        tw = touched_words();
        in_commit = (tw > 0);
        txn_close = 1'b1;
        @(negedge clk);
        txn_close = 1'b0;
        if (tw > 0)
            check(busy == 1'b1, "R5", {tag, " busy after close"}, 32'(busy), 32'h1);
        else
            check(busy == 1'b0, "R9", {tag, " busy on empty close"}, 32'(busy), 32'h0);
        if (extra_while_busy) begin
            // R11: all of these must be ignored while busy
            txn_start = 1'b1; start_addr = {epage, 7'd0};
            @(negedge clk);
            txn_start = 1'b0;
            byte_valid = 1'b1; byte_data = 8'hEE;
            @(negedge clk);
            byte_valid = 1'b0;
            txn_close = 1'b1;
            @(negedge clk);
            txn_close = 1'b0;
        end
        lim = 0;
        while (busy && lim < 5000) begin
            @(negedge clk);
            lim++;
        end
        in_commit = 0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R8", {tag, " busy ends"}, 32'(busy), 32'h0);
        check(wr_cnt == tw, "R7", {tag, " write count"}, 32'(wr_cnt), 32'(tw));
        if (tw == 0)
            check(acc_cnt == 0, "R9", {tag, " no access"}, 32'(acc_cnt), 32'h0);
        ok = 1;
        for (int w = 0; w < 32; w++) begin
            if (bmem[w] !== exp_word(w)) begin
                ok = 0;
                $display("FAIL R6 %s word %0d: actual=%h expected=%h", tag, w, bmem[w], exp_word(w));
            end
        end
        n_checks++;
        if (!ok) n_errors++;
    endtask

    initial begin
        logic [15:0] a;
        int len;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1", "busy in reset", 32'(busy), 32'h0);
        check(mem_req == 1'b0, "R1", "req in reset", 32'(mem_req), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && mem_req == 1'b0, "R1", "idle after reset", 32'({busy, mem_req}), 32'h0);

        // R2/R6: single byte in the middle of a word, merge of other lanes
        prep_page(9'h0A5);
        do_start({9'h0A5, 7'd5});
        do_byte(8'h3C, 1);
        close_and_check("R2 single byte", 0);

        // R2: contiguous run with gaps
        prep_page(9'h011);
        do_start({9'h011, 7'd30});
        for (int i = 0; i < 17; i++) begin
            do_byte(8'(i * 7 + 1), 1);
            if (i % 3 == 0) @(negedge clk);
        end
        close_and_check("R2 run", 0);

        // R3: wrap from 127 to 0
        prep_page(9'h1FF);
        do_start({9'h1FF, 7'd122});
        for (int i = 0; i < 10; i++) do_byte(8'(8'hA0 + i), 1);
        close_and_check("R3 wrap", 0);

        // R3: more than a page, overwrite of early slots
        prep_page(9'h042);
        do_start({9'h042, 7'd3});
        for (int i = 0; i < 133; i++) do_byte(8'(i), 1);
        close_and_check("R3 overwrite", 0);

        // R9: empty transaction
        prep_page(9'h077);
        do_start({9'h077, 7'd9});
        close_and_check("R9 empty", 0);

        // R10: restart without close clears the earlier valid flags
        prep_page(9'h100);
        do_start({9'h100, 7'd0});
        do_byte(8'h11, 0);
        do_byte(8'h22, 0);
        do_start({9'h100, 7'd40});
        do_byte(8'h55, 1);
        close_and_check("R10 restart", 0);

        // R11: inputs while busy are ignored
        prep_page(9'h0C3);
        do_start({9'h0C3, 7'd0});
        for (int i = 0; i < 128; i++) do_byte(8'(i ^ 8'h5A), 1);
        close_and_check("R11 busy ignore", 1);
        check(acc_cnt == 64, "R11", "no second commit", 32'(acc_cnt), 32'd64);

        // R11: stray bytes and close outside a transaction
        prep_page(9'h0C3);
        do_byte(8'h99, 0);
        txn_close = 1'b1;
        @(negedge clk);
        txn_close = 1'b0;
        check(busy == 1'b0, "R11", "close outside txn", 32'(busy), 32'h0);
        repeat (3) @(negedge clk);
        check(acc_cnt == 0, "R11", "no access outside txn", 32'(acc_cnt), 32'h0);

        // random transactions
        for (int t = 0; t < 16; t++) begin
            a = 16'($urandom);
            len = int'($urandom % 200);
            prep_page(a[15:7]);
            do_start(a);
            for (int i = 0; i < len; i++) begin
                do_byte(8'($urandom), 1);
                if ($urandom % 4 == 0) @(negedge clk);
            end
            close_and_check("R2 random", 0);
        end

        summary();
    end

endmodule